// File: doc/BRIEF.md
# Local Interrupt Controller Register Bank with Message Launch

This block is the software-visible register file of a per-core interrupt controller. Accesses arrive one per cycle on a simple request port carrying an address, a byte-count code, a write flag and write data. The register is chosen by the address with its three least significant bits ignored. Named registers sit 16 bytes apart. Each register has its own write rule. Some fields are masked away, some are forced to one and some are read-only. One register clears only on a second write. A write to one register has no effect while the message it launched is still pending.

The command register pair launches inter-processor messages. Software first writes the high word, which carries the destination. It then writes the low word, which carries the vector, delivery mode, destination mode, level, trigger and shorthand. The low-word write latches its fields and sets a busy (delivery-status) bit. It also presents a message on a valid/ready output port. The message stays valid with every field stable until the receiver asserts ready. The busy bit clears on that handshake. While busy is set, further low-word writes are dropped, so back-pressure from the receiver reaches software as a busy bit it can poll.

Read data returns one cycle after the access with a valid strobe. An illegal access is either a reserved offset or a byte span that leaves its 8-byte slot. It does not touch any register, reads zero, raises an error pulse and records the cause in the error-status register.

Top module: `intc_reg_bank`

## Requirements
- R1: The register is selected by the address with bits 2:0 ignored. Offsets 0x020 (identity), 0x030 (version), 0x080 (task priority), 0x0B0 (end-of-interrupt), 0x0D0 (logical destination), 0x0E0 (destination format), 0x0F0 (spurious vector), 0x280 (error status), 0x300/0x310 (command low/high) and 0x320 + 16*k for k below N_LVT (local vector entries) are named; every other offset is reserved. A reserved access changes no register, reads zero, pulses `acc_err` and sets error-status bit 1.
- R2: An access covers 2**`acc_size` bytes starting at `acc_addr`. If its last byte lies beyond bit position 7 of the 8-byte slot (addr[2:0] + bytes > 8), the access is illegal: no register changes, a read returns zero, `acc_err` pulses and error-status bit 0 is set.
- R3: Every access with `acc_write` low produces `rd_valid` high for exactly the next cycle, with `rd_data`. `acc_err` for any access appears in that same next cycle.
- R4: Identity and task-priority writes keep only bits 7:0. Logical-destination writes keep only bits 31:24. The version register ignores writes and reads VERSION_VAL. End-of-interrupt accepts writes without error and reads zero.
- R5: Destination format resets to 0xFFFFFFFF, and any write stores the data with bits 27:0 forced to one.
- R6: Each local vector entry resets to 0x00010000. On a write, bits 12 and 14 keep their previous value and all other bits take the write data.
- R7: A spurious-vector write stores its data, and `sw_enable` follows bit 8 of the stored value from the cycle after the write.
- R8: The error-status register has a hidden arm flag, clear after reset. A write when not armed only arms it. A write when armed clears the register to zero and disarms. A read returns the value and disarms.
- R9: A command-low write while idle latches vector [7:0], delivery mode [10:8], destination mode [11], level [14], trigger [15] and shorthand [19:18]. It sets delivery status (bit 12 on read-back). From the next cycle it drives `msg_valid` with the destination taken from command-high bits 31:24 at that moment.
- R10: A command-low write while delivery status is set is ignored: the read-back value and the pending message are unchanged. Command-high writes are always stored but do not alter a message already pending.
- R11: While `msg_valid` is high and `msg_ready` low, `msg_valid` and every message field hold. After a cycle with both high, `msg_valid` is low and delivery status reads zero.
- R12: The shorthand code is carried unchanged on `msg_shorthand`. 0 means explicit destination, 1 means self, 2 means all including self and 3 means all excluding self.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Byte offset of the access |
| acc_size | input | 2 | Byte count code, 2**code bytes |
| acc_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after a read) |
| rd_data | output | 32 | Read data |
| acc_err | output | 1 | Illegal access pulse (one cycle after the access) |
| sw_enable | output | 1 | Software enable, bit 8 of spurious vector |
| msg_valid | output | 1 | Message pending |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_dest | output | 8 | Destination |
| msg_vector | output | 8 | Vector |
| msg_mode | output | 3 | Delivery mode |
| msg_dest_logical | output | 1 | Destination mode (1 = logical) |
| msg_level | output | 1 | Level |
| msg_trigger | output | 1 | Trigger mode |
| msg_shorthand | output | 2 | Destination shorthand |

## Verification
The assertions assume that `msg_ready` is only meaningful while `msg_valid` is high. They also assume that `acc_valid`, `acc_write` and the other request inputs are driven to known values from reset onward, because the read strobe and error pulse are tied to the previous cycle's request. The bench drives every request input from one task, between clock edges. It holds `acc_valid` low while reset is applied and changes `msg_ready` only just after a rising edge. Every stall and handshake therefore falls on a clean edge that the stability and drop properties can judge.

// File: rtl/intc_regs_pkg.sv
package intc_regs_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_ID,
    SEL_VER,
    SEL_TPRI,
    SEL_EOI,
    SEL_LDEST,
    SEL_DFMT,
    SEL_SPUR,
    SEL_ESTAT,
    SEL_CMDL,
    SEL_CMDH,
    SEL_LVT
  } reg_sel_e;

  localparam int OFS_ID    = 'h020;
  localparam int OFS_VER   = 'h030;
  localparam int OFS_TPRI  = 'h080;
  localparam int OFS_EOI   = 'h0B0;
  localparam int OFS_LDEST = 'h0D0;
  localparam int OFS_DFMT  = 'h0E0;
  localparam int OFS_SPUR  = 'h0F0;
  localparam int OFS_ESTAT = 'h280;
  localparam int OFS_CMDL  = 'h300;
  localparam int OFS_CMDH  = 'h310;
  localparam int OFS_LVT0  = 'h320;

  localparam int CMD_STATUS_BIT = 12;

endpackage

// File: rtl/intc_addr_decode.sv
module intc_addr_decode
  import intc_regs_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int N_LVT     = 6,
  parameter int LVT_IDX_W = 3
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [1:0]           size,
  output reg_sel_e             sel,
  output logic [LVT_IDX_W-1:0] lvt_idx,
  output logic                 span_bad
);

  localparam int SLOT_LO = OFS_LVT0 / 16;

  logic [ADDR_W-1:0] base;
  int                base_i;
  int                slot_i;
  logic [3:0]        last_byte;

  always_comb begin
    base    = {addr[ADDR_W-1:3], 3'b000};
    base_i  = int'(base);
    slot_i  = base_i / 16;
    sel     = SEL_NONE;
    lvt_idx = '0;
    case (base_i)
      OFS_ID:    sel = SEL_ID;
      OFS_VER:   sel = SEL_VER;
      OFS_TPRI:  sel = SEL_TPRI;
      OFS_EOI:   sel = SEL_EOI;
      OFS_LDEST: sel = SEL_LDEST;
      OFS_DFMT:  sel = SEL_DFMT;
      OFS_SPUR:  sel = SEL_SPUR;
      OFS_ESTAT: sel = SEL_ESTAT;
      OFS_CMDL:  sel = SEL_CMDL;
      OFS_CMDH:  sel = SEL_CMDH;
      default: begin
        if (base[3] == 1'b0 && slot_i >= SLOT_LO && slot_i < SLOT_LO + N_LVT) begin
          sel     = SEL_LVT;
          lvt_idx = LVT_IDX_W'(slot_i - SLOT_LO);
        end
      end
    endcase
  end

  // last byte touched, relative to the slot start
  always_comb begin
    last_byte = {1'b0, addr[2:0]} + (4'd1 << size) - 4'd1;
    span_bad  = last_byte[3];
  end

endmodule

// File: rtl/intc_lvt_entry.sv
module intc_lvt_entry #(
  parameter int          DW      = 32,
  parameter logic [31:0] INIT    = 32'h0001_0000,
  parameter logic [31:0] RO_MASK = 32'h0000_5000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] value
);

  localparam logic [DW-1:0] KEEP = DW'(RO_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  value <= DW'(INIT);
    else if (we) value <= (wdata & ~KEEP) | (value & KEEP);
  end

endmodule

// File: rtl/intc_cmd_launch.sv
module intc_cmd_launch #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_low,
  input  logic          wr_high,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] low_rd,
  output logic [DW-1:0] high_rd,
  output logic          msg_valid,
  input  logic          msg_ready,
  output logic [7:0]    msg_dest,
  output logic [7:0]    msg_vector,
  output logic [2:0]    msg_mode,
  output logic          msg_dest_logical,
  output logic          msg_level,
  output logic          msg_trigger,
  output logic [1:0]    msg_shorthand
);

  localparam int SB = intc_regs_pkg::CMD_STATUS_BIT;

  logic [DW-1:0] low_q;
  logic [DW-1:0] high_q;
  logic [7:0]    dest_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      high_q <= '0;
      dest_q <= '0;
      busy_q <= 1'b0;
    end else begin
      if (wr_high) high_q <= wdata;
      if (wr_low && !busy_q) begin
        low_q  <= wdata;
        dest_q <= high_q[31:24];
        busy_q <= 1'b1;
      end else if (busy_q && msg_ready) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    low_rd     = low_q;
    low_rd[SB] = busy_q;
    high_rd    = high_q;
  end

  assign msg_valid        = busy_q;
  assign msg_dest         = dest_q;
  assign msg_vector       = low_q[7:0];
  assign msg_mode         = low_q[10:8];
  assign msg_dest_logical = low_q[11];
  assign msg_level        = low_q[14];
  assign msg_trigger      = low_q[15];
  assign msg_shorthand    = low_q[19:18];

endmodule

// File: rtl/intc_reg_bank.sv
module intc_reg_bank
  import intc_regs_pkg::*;
#(
  parameter int          ADDR_W      = 12,
  parameter int          N_LVT       = 6,
  parameter logic [31:0] VERSION_VAL = 32'h0005_0014,
  parameter logic [7:0]  ID_INIT     = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [31:0]       acc_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              acc_err,
  output logic              sw_enable,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [7:0]        msg_dest,
  output logic [7:0]        msg_vector,
  output logic [2:0]        msg_mode,
  output logic              msg_dest_logical,
  output logic              msg_level,
  output logic              msg_trigger,
  output logic [1:0]        msg_shorthand
);

  localparam int DW        = 32;
  localparam int LVT_IDX_W = (N_LVT > 1) ? $clog2(N_LVT) : 1;

  reg_sel_e             sel;
  logic [LVT_IDX_W-1:0] lvt_idx;
  logic                 span_bad;
  logic                 access_ok, wr, rd;

  logic [DW-1:0] id_q, tpri_q, ldest_q, dfmt_q, spur_q, estat_q;
  logic          estat_armed;
  logic [DW-1:0] cmd_low, cmd_high;
  logic [DW-1:0] lvt_val [N_LVT];
  logic [DW-1:0] rd_next;

  intc_addr_decode #(
    .ADDR_W(ADDR_W), .N_LVT(N_LVT), .LVT_IDX_W(LVT_IDX_W)
  ) u_dec (
    .addr(acc_addr), .size(acc_size), .sel(sel), .lvt_idx(lvt_idx), .span_bad(span_bad)
  );

  assign access_ok = !span_bad && (sel != SEL_NONE);
  assign wr        = acc_valid && acc_write && access_ok;
  assign rd        = acc_valid && !acc_write && access_ok;

  for (genvar k = 0; k < N_LVT; k++) begin : g_lvt
    intc_lvt_entry #(.DW(DW)) u_entry (
      .clk(clk), .rst_n(rst_n),
      .we(wr && sel == SEL_LVT && lvt_idx == LVT_IDX_W'(k)),
      .wdata(acc_wdata), .value(lvt_val[k])
    );
  end

  intc_cmd_launch #(.DW(DW)) u_cmd (
    .clk(clk), .rst_n(rst_n),
    .wr_low(wr && sel == SEL_CMDL), .wr_high(wr && sel == SEL_CMDH),
    .wdata(acc_wdata), .low_rd(cmd_low), .high_rd(cmd_high),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_dest(msg_dest), .msg_vector(msg_vector), .msg_mode(msg_mode),
    .msg_dest_logical(msg_dest_logical), .msg_level(msg_level),
    .msg_trigger(msg_trigger), .msg_shorthand(msg_shorthand)
  );

  // plain registers with their write rules
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q    <= {24'h0, ID_INIT};
      tpri_q  <= '0;
      ldest_q <= '0;
      dfmt_q  <= '1;
      spur_q  <= 32'h0000_00FF;
    end else if (wr) begin
      case (sel)
        SEL_ID:    id_q    <= acc_wdata & 32'h0000_00FF;
        SEL_TPRI:  tpri_q  <= acc_wdata & 32'h0000_00FF;
        SEL_LDEST: ldest_q <= acc_wdata & 32'hFF00_0000;
        SEL_DFMT:  dfmt_q  <= acc_wdata | 32'h0FFF_FFFF;
        SEL_SPUR:  spur_q  <= acc_wdata;
        default: ;
      endcase
    end
  end

  assign sw_enable = spur_q[8];

  // error status: two-write clear, read disarms, illegal accesses set causes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      estat_q     <= '0;
      estat_armed <= 1'b0;
    end else begin
      if (acc_valid && span_bad)                  estat_q[0] <= 1'b1;
      else if (acc_valid && sel == SEL_NONE)      estat_q[1] <= 1'b1;
      if (rd && sel == SEL_ESTAT) estat_armed <= 1'b0;
      if (wr && sel == SEL_ESTAT) begin
        if (estat_armed) begin
          estat_q     <= '0;
          estat_armed <= 1'b0;
        end else begin
          estat_armed <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_next = '0;
    if (rd) begin
      case (sel)
        SEL_ID:    rd_next = id_q;
        SEL_VER:   rd_next = VERSION_VAL;
        SEL_TPRI:  rd_next = tpri_q;
        SEL_LDEST: rd_next = ldest_q;
        SEL_DFMT:  rd_next = dfmt_q;
        SEL_SPUR:  rd_next = spur_q;
        SEL_ESTAT: rd_next = estat_q;
        SEL_CMDL:  rd_next = cmd_low;
        SEL_CMDH:  rd_next = cmd_high;
        SEL_LVT:   rd_next = lvt_val[lvt_idx];
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      acc_err  <= 1'b0;
    end else begin
      rd_valid <= acc_valid && !acc_write;
      rd_data  <= rd_next;
      acc_err  <= acc_valid && !access_ok;
    end
  end

endmodule

// File: rtl/intc_reg_bank_chk.sv
module intc_reg_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic        acc_write,
  input logic        rd_valid,
  input logic [31:0] rd_data,
  input logic        acc_err,
  input logic        sw_enable,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [7:0]  msg_dest,
  input logic [7:0]  msg_vector,
  input logic [2:0]  msg_mode,
  input logic [1:0]  msg_shorthand
);

  // R11
  msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_dest) && $stable(msg_vector)
      && $stable(msg_mode) && $stable(msg_shorthand));

  // R11
  msg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid);

  // R3
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_valid && !acc_write));

  // R3
  rd_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_write |=> rd_valid);

  // R2
  err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(acc_valid));

  // R1
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err && rd_valid |-> rd_data == 32'h0);

  // R7
  sw_enable_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sw_enable) |-> $past(acc_valid && acc_write));

endmodule

bind intc_reg_bank intc_reg_bank_chk u_chk (.*);

// File: tb/intc_reg_bank_bench.sv
module intc_reg_bank_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } rd_exp_t;

  typedef struct {
    logic [23:0] word;
    string       tag;
  } msg_exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [11:0] acc_addr = '0;
  logic [1:0]  acc_size = 2'd2;
  logic [31:0] acc_wdata = '0;
  logic        msg_ready = 1'b0;
  logic        rd_valid, acc_err, sw_enable, msg_valid;
  logic [31:0] rd_data;
  logic [7:0]  msg_dest, msg_vector;
  logic [2:0]  msg_mode;
  logic        msg_dest_logical, msg_level, msg_trigger;
  logic [1:0]  msg_shorthand;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  rd_exp_t  rd_q[$];
  msg_exp_t msg_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_reg_bank u_intc_reg_bank (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err), .sw_enable(sw_enable),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_dest(msg_dest),
    .msg_vector(msg_vector), .msg_mode(msg_mode), .msg_dest_logical(msg_dest_logical),
    .msg_level(msg_level), .msg_trigger(msg_trigger), .msg_shorthand(msg_shorthand)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one access, one cycle
  task automatic access(input bit w, input logic [11:0] a, input logic [1:0] sz,
                        input logic [31:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_addr = a; acc_size = sz; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit exp_err, input string tag);
    access(1'b1, a, 2'd2, d);
    check(acc_err == exp_err, tag, {31'h0, acc_err}, {31'h0, exp_err});
  endtask

  task automatic wr_sz(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] d,
                       input bit exp_err, input string tag);
    access(1'b1, a, sz, d);
    check(acc_err == exp_err, tag, {31'h0, acc_err}, {31'h0, exp_err});
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] sz, input logic [31:0] exp,
                    input bit exp_err, input string tag);
    rd_exp_t e;
    e.data = exp; e.err = exp_err; e.tag = tag;
    rd_q.push_back(e);
    access(1'b0, a, sz, 32'h0);
  endtask

  task automatic set_ready(input logic v);
    @(posedge clk);
    #1 msg_ready = v;
  endtask

  function automatic logic [31:0] cmd_word(input logic [7:0] vec, input logic [2:0] mode,
                                          input logic dm, input logic lvl, input logic trg,
                                          input logic [1:0] sh);
    return {12'h0, sh, 2'b00, trg, lvl, 1'b0, 1'b0, dm, mode, vec};
  endfunction

  task automatic expect_msg(input logic [7:0] dst, input logic [31:0] low, input string tag);
    msg_exp_t m;
    m.word = {dst, low[7:0], low[10:8], low[11], low[14], low[15], low[19:18]};
    m.tag  = tag;
    msg_q.push_back(m);
  endtask

  // read monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (rd_q.size() == 0) begin
        check(1'b0, "R3 unexpected read data", rd_data, 32'h0);
      end else begin
        rd_exp_t e;
        e = rd_q.pop_front();
        check(rd_data == e.data, e.tag, rd_data, e.data);
        check(acc_err == e.err, {e.tag, " err"}, {31'h0, acc_err}, {31'h0, e.err});
      end
    end
  end

  // message monitor
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      logic [23:0] got;
      got = {msg_dest, msg_vector, msg_mode, msg_dest_logical, msg_level, msg_trigger, msg_shorthand};
      if (msg_q.size() == 0) begin
        check(1'b0, "R10 unexpected message", {8'h0, got}, 32'h0);
      end else begin
        msg_exp_t m;
        m = msg_q.pop_front();
        check(got == m.word, m.tag, {8'h0, got}, {8'h0, m.word});
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check(msg_valid == 1'b0, "R9 reset idle", {31'h0, msg_valid}, 32'h0);
    check(sw_enable == 1'b0, "R7 reset sw_enable", {31'h0, sw_enable}, 32'h0);
    rd(12'h020, 2'd2, 32'h0000_0000, 1'b0, "R4 id reset");
    rd(12'h030, 2'd2, 32'h0005_0014, 1'b0, "R4 version");
    rd(12'h0E0, 2'd2, 32'hFFFF_FFFF, 1'b0, "R5 dfmt reset");
    rd(12'h320, 2'd2, 32'h0001_0000, 1'b0, "R6 lvt reset");
    rd(12'h300, 2'd2, 32'h0000_0000, 1'b0, "R9 cmd low reset");

    // masked writes
    wr(12'h020, 32'hABCD_EF12, 1'b0, "R4 id write");
    rd(12'h020, 2'd2, 32'h0000_0012, 1'b0, "R4 id mask");
    wr(12'h080, 32'hFFFF_FF5A, 1'b0, "R4 tpri write");
    rd(12'h084, 2'd2, 32'h0000_005A, 1'b0, "R1 tpri low bits ignored");
    wr(12'h0D0, 32'h1234_5678, 1'b0, "R4 ldest write");
    rd(12'h0D0, 2'd2, 32'h1200_0000, 1'b0, "R4 ldest mask");
    wr(12'h030, 32'h1111_1111, 1'b0, "R4 version write");
    rd(12'h030, 2'd2, 32'h0005_0014, 1'b0, "R4 version read-only");
    wr(12'h0B0, 32'hFFFF_FFFF, 1'b0, "R4 eoi write");
    rd(12'h0B0, 2'd2, 32'h0000_0000, 1'b0, "R4 eoi reads zero");

    // destination format
    wr(12'h0E0, 32'h0000_0000, 1'b0, "R5 dfmt write");
    rd(12'h0E0, 2'd2, 32'h0FFF_FFFF, 1'b0, "R5 dfmt forced ones");
    wr(12'h0E0, 32'hA000_0000, 1'b0, "R5 dfmt write2");
    rd(12'h0E0, 2'd2, 32'hAFFF_FFFF, 1'b0, "R5 dfmt top bits");

    // vector entries
    for (int k = 0; k < 6; k++) begin
      wr(12'h320 + 12'(k * 16), 32'hFFFF_FFFF, 1'b0, "R6 lvt write");
      rd(12'h320 + 12'(k * 16), 2'd2, 32'hFFFF_AFFF, 1'b0, "R6 lvt read-only bits");
    end
    wr(12'h350, 32'h0000_0000, 1'b0, "R6 lvt clear");
    rd(12'h350, 2'd2, 32'h0000_0000, 1'b0, "R6 lvt cleared");
    rd(12'h340, 2'd2, 32'hFFFF_AFFF, 1'b0, "R6 neighbour untouched");

    // spurious vector
    wr(12'h0F0, 32'h0000_0100, 1'b0, "R7 spur write");
    check(sw_enable == 1'b1, "R7 sw_enable set", {31'h0, sw_enable}, 32'h1);
    rd(12'h0F0, 2'd2, 32'h0000_0100, 1'b0, "R7 spur read");
    wr(12'h0F0, 32'h0000_00FF, 1'b0, "R7 spur write2");
    check(sw_enable == 1'b0, "R7 sw_enable clear", {31'h0, sw_enable}, 32'h0);

    // illegal accesses
    rd(12'h040, 2'd2, 32'h0, 1'b1, "R1 reserved read");
    rd(12'h328, 2'd2, 32'h0, 1'b1, "R1 reserved odd slot");
    wr(12'h390, 32'hFFFF_FFFF, 1'b1, "R1 reserved write");
    rd(12'h280, 2'd2, 32'h0000_0002, 1'b0, "R1 estat reserved bit");
    wr_sz(12'h086, 2'd2, 32'h0000_0077, 1'b1, "R2 span write");
    rd(12'h080, 2'd2, 32'h0000_005A, 1'b0, "R2 span write no effect");
    rd(12'h086, 2'd1, 32'h0000_005A, 1'b0, "R2 two bytes at 6 legal");
    rd(12'h081, 2'd3, 32'h0, 1'b1, "R2 span read");
    rd(12'h280, 2'd2, 32'h0000_0003, 1'b0, "R2 estat span bit");

    // error status arm/clear
    wr(12'h280, 32'h0, 1'b0, "R8 arm");
    rd(12'h280, 2'd2, 32'h0000_0003, 1'b0, "R8 arm keeps value");
    wr(12'h280, 32'h0, 1'b0, "R8 re-arm after read");
    rd(12'h280, 2'd2, 32'h0000_0003, 1'b0, "R8 read disarms");
    wr(12'h280, 32'h0, 1'b0, "R8 arm again");
    wr(12'h280, 32'h0, 1'b0, "R8 second write");
    rd(12'h280, 2'd2, 32'h0000_0000, 1'b0, "R8 cleared");

    // message launch with back-pressure
    wr(12'h310, 32'h0500_0000, 1'b0, "R9 cmd high");
    expect_msg(8'h05, cmd_word(8'h41, 3'd4, 1'b1, 1'b1, 1'b1, 2'd2), "R9 message fields");
    wr(12'h300, cmd_word(8'h41, 3'd4, 1'b1, 1'b1, 1'b1, 2'd2), 1'b0, "R9 cmd low");
    check(msg_valid == 1'b1, "R9 launch", {31'h0, msg_valid}, 32'h1);
    rd(12'h300, 2'd2, cmd_word(8'h41, 3'd4, 1'b1, 1'b1, 1'b1, 2'd2) | 32'h1000, 1'b0, "R9 status bit");
    wr(12'h310, 32'h0900_0000, 1'b0, "R10 high while busy");
    wr(12'h300, cmd_word(8'h22, 3'd0, 1'b0, 1'b0, 1'b0, 2'd0), 1'b0, "R10 low while busy");
    rd(12'h300, 2'd2, cmd_word(8'h41, 3'd4, 1'b1, 1'b1, 1'b1, 2'd2) | 32'h1000, 1'b0, "R10 ignored");
    check(msg_vector == 8'h41 && msg_dest == 8'h05, "R11 held under stall",
          {16'h0, msg_dest, msg_vector}, 32'h0000_0541);
    set_ready(1'b1);
    set_ready(1'b0);
    @(negedge clk);
    check(msg_valid == 1'b0, "R11 drop after handshake", {31'h0, msg_valid}, 32'h0);
    rd(12'h300, 2'd2, cmd_word(8'h41, 3'd4, 1'b1, 1'b1, 1'b1, 2'd2), 1'b0, "R11 status cleared");
    rd(12'h310, 2'd2, 32'h0900_0000, 1'b0, "R10 high stored");

    // shorthand codes, receiver always ready
    set_ready(1'b1);
    for (int s = 0; s < 4; s++) begin
      expect_msg(8'h09, cmd_word(8'h30 + 8'(s), 3'(s), s[0], 1'b0, s[1], 2'(s)), "R12 shorthand");
      wr(12'h300, cmd_word(8'h30 + 8'(s), 3'(s), s[0], 1'b0, s[1], 2'(s)), 1'b0, "R12 launch");
      repeat (2) @(negedge clk);
    end
    set_ready(1'b0);
    repeat (3) @(negedge clk);

    check(rd_q.size() == 0, "R3 all reads returned", rd_q.size(), 0);
    check(msg_q.size() == 0, "R12 all messages seen", msg_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule